// File: doc/BRIEF.md
# Programmable Interrupt Line Driver

This block takes one internal interrupt request and presents it on one of six bus interrupt pins. The pins stand for bus request numbers 4, 5, 9, 10, 11 and 12, in that order. Each pin is modelled as a tri-state output with a data bit and an output-enable bit. A small configuration register sets which pin is in use and how it signals. In edge signalling the chosen pin is always driven, high for a pending request and low otherwise. In level signalling the pin behaves as an open-drain line: it pulls low while a request is pending and floats otherwise. Every pin that is not chosen stays floating, whatever the request does.

The configuration register is loaded through a plain write strobe with a 4-bit word. No data stream passes through the block, so its edge has no valid/ready handshake: the write strobe and the request are plain control pins, sampled on every rising clock edge. When a write changes the stored word, every pin is held off for one cycle, so that a newly chosen pin is never enabled while its selection or mode is still settling. An active-high reset floats every pin at once, without waiting for a clock edge, and clears the selection to "no line".

Top module: `irq_line_drv`

## Requirements
- R1: While `rst` is high, every bit of `pin_oe` is 0 at once, with no clock edge needed. After reset the stored index is 7 (no line) and the mode is edge, so `pin_oe` stays all zero until a write.
- R2: At most one bit of `pin_oe` is 1 at any time.
- R3: Mode bit 0 selects edge signalling. The chosen pin has `pin_oe`=1, and its `pin_dat` equals the request registered at the previous clock edge.
- R4: Mode bit 1 selects level (open-drain) signalling. The chosen pin has `pin_dat`=0, and its `pin_oe` equals the registered request.
- R5: Every pin other than the chosen one has `pin_oe`=0 and `pin_dat`=0, even while the request is high.
- R6: Index values 0 to 5 choose `pin_oe`/`pin_dat` bit 0 to 5. Index values 6 and 7 choose no pin, so all outputs are 0.
- R7: When `cfg_wr_en` is high at a clock edge and `cfg_wr_data` differs from the stored word, the word is stored at that edge. All `pin_oe` bits are 0 for the following cycle, and the new setting drives the pins from the edge after that.
- R8: A write whose data equals the stored word has no effect on the pins. No blanking cycle is inserted.
- R9: `irq_req` is sampled on the rising clock edge, so the pins follow it one cycle later.
- R10: When `cfg_wr_en` is low, `cfg_wr_data` has no effect. The write word is laid out as bits [2:0] index and bit [3] mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, asynchronous |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 4 | Bits [2:0] line index, bit [3] mode (0 edge, 1 level) |
| irq_req | input | 1 | Internal interrupt request, active high |
| pin_dat | output | 6 | Data value of each interrupt pin |
| pin_oe | output | 6 | Output enable of each interrupt pin |

## Verification
The hardest case to reach is the blanking cycle. Something must be pending and a pin must be live when a write arrives that moves the request to another pin or flips its mode. Only then does the one cycle of all-off output differ from an ordinary switch-over. The stimulus therefore holds the request high through a chain of changing writes. It then repeats a write of the same word, to show that no blank is inserted. It also asserts reset midway between clock edges while a level-mode pin is pulling low, which shows that the pins are released without a clock edge.

// File: rtl/irq_drv_pkg.sv
package irq_drv_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_drv_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_mode,
  output logic [IDX_W-1:0] idx_q,
  output sig_mode_e        mode_q,
  output logic             blank_q
);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  logic changed;
  assign changed = (wr_idx != idx_q) || (wr_mode != logic'(mode_q));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idx_q   <= IDX_NONE;
      mode_q  <= MODE_EDGE;
      blank_q <= 1'b0;
    end else begin
      blank_q <= wr_en && changed;
      if (wr_en) begin
        idx_q  <= wr_idx;
        mode_q <= sig_mode_e'(wr_mode);
      end
    end
  end

  // R10: without a write strobe the stored word holds
  assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(idx_q) && $stable(mode_q)));
endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode #(
  parameter int unsigned NUM_LINES = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 enable,
  output logic [NUM_LINES-1:0] sel
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
    assign sel[i] = enable && (idx == IDX_W'(i));
  end

  // R6: out-of-range index selects nothing
  always_comb begin
    if (!$isunknown(idx) && (int'(idx) >= NUM_LINES)) begin
      assert_no_sel_R6: assert (sel == '0);
    end
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import irq_drv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 irq_req,
  input  sig_mode_e            mode,
  input  logic [NUM_LINES-1:0] sel,
  output logic [NUM_LINES-1:0] pin_dat,
  output logic [NUM_LINES-1:0] pin_oe
);
  logic req_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= irq_req;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pin
    always_comb begin
      pin_dat[i] = 1'b0;
      pin_oe[i]  = 1'b0;
      if (sel[i] && !rst) begin
        if (mode == MODE_EDGE) begin
          pin_oe[i]  = 1'b1;
          pin_dat[i] = req_q;
        end else begin
          pin_oe[i]  = req_q;
        end
      end
    end
  end

  // R3: edge mode keeps the chosen pin driven
  assert_edge_driven_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_EDGE) |-> (pin_oe == sel));
  // R4: level mode never drives a high level
  assert_level_low_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LEVEL) |-> (pin_dat == '0));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import irq_drv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr_en,
  input  logic [3:0]           cfg_wr_data,
  input  logic                 irq_req,
  output logic [NUM_LINES-1:0] pin_dat,
  output logic [NUM_LINES-1:0] pin_oe
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES + 1);

  logic [IDX_W-1:0]     idx_q;
  sig_mode_e            mode_q;
  logic                 blank_q;
  logic [NUM_LINES-1:0] sel;

  irq_cfg_reg #(.IDX_W(IDX_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_data[IDX_W-1:0]),
    .wr_mode (cfg_wr_data[3]),
    .idx_q   (idx_q),
    .mode_q  (mode_q),
    .blank_q (blank_q)
  );

  irq_line_decode #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_dec (
    .idx    (idx_q),
    .enable (!blank_q),
    .sel    (sel)
  );

  irq_pin_drive #(.NUM_LINES(NUM_LINES)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .irq_req (irq_req),
    .mode    (mode_q),
    .sel     (sel),
    .pin_dat (pin_dat),
    .pin_oe  (pin_oe)
  );

  // R1: first cycle after reset release has every pin floating
  assert_reset_float_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0));
  // R2: never more than one live pin
  assert_single_line_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_oe));
  // R5: nothing enabled outside the decoded selection
  assert_unsel_float_R5: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~sel) == '0);
  // R7: a changing write blanks all pins in the next cycle
  assert_blank_on_change_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && (cfg_wr_data != {logic'(mode_q), idx_q})) |=> (pin_oe == '0));
endmodule

// File: tb/tb_irq_line_drv.sv
module tb_irq_line_drv;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_wr_en = 1'b0;
  logic [3:0]   cfg_wr_data = 4'd0;
  logic         irq_req = 1'b0;
  logic [N-1:0] pin_dat;
  logic [N-1:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_line_drv dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .irq_req(irq_req), .pin_dat(pin_dat), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  int m_idx = 7, m_mode = 0, m_blank = 0, m_req = 0;
  int m_same = 0, m_nowr = 0;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_idx = 7; m_mode = 0; m_blank = 0; m_req = 0; m_same = 0; m_nowr = 0;
    end else begin
      m_req = irq_req;
      m_same = 0; m_nowr = !cfg_wr_en;
      if (cfg_wr_en) begin
        if (int'(cfg_wr_data[2:0]) == m_idx && int'(cfg_wr_data[3]) == m_mode) begin
          m_blank = 0; m_same = 1;
        end else begin
          m_blank = 1;
        end
        m_idx = cfg_wr_data[2:0];
        m_mode = cfg_wr_data[3];
      end else begin
        m_blank = 0;
      end
    end
  end

  function automatic string pick_tag();
    if (rst)         return "R1";
    if (m_blank != 0) return "R7";
    if (m_idx >= N)  return "R6";
    if (m_same != 0) return "R8";
    if (m_nowr != 0) return "R10";
    return (m_mode != 0) ? "R4" : "R3";
  endfunction

  // compare against the model on every falling edge
  always @(negedge clk) begin
    logic [N-1:0] e_oe;
    logic [N-1:0] e_dat;
    if (!done) begin
      e_oe = '0; e_dat = '0;
      for (int i = 0; i < N; i++) begin
        if (!rst && m_blank == 0 && m_idx == i) begin
          if (m_mode == 0) begin e_oe[i] = 1'b1; e_dat[i] = (m_req != 0); end
          else             begin e_oe[i] = (m_req != 0); end
        end
      end
      // R5 and R9 are covered here: unselected bits must be zero, data lags irq_req by one edge
      checks++;
      if (pin_oe !== e_oe || pin_dat !== e_dat) begin
        errors++;
        $display("FAIL %s: oe=%b dat=%b expected oe=%b dat=%b at %0t",
                 pick_tag(), pin_oe, pin_dat, e_oe, e_dat, $time);
      end
      checks++;
      if ($countones(pin_oe) > 1) begin
        errors++;
        $display("FAIL R2: oe=%b expected at most one bit set", pin_oe);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    step(1);
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(2);                        // R1: reset state, no pin live
    irq_req = 1'b1; step(2);        // R6: index 7 after reset, request ignored
    wr(4'b0_000); step(2);          // R3: edge mode, line 0 high
    irq_req = 1'b0; step(2);        // R9: drop follows one edge later
    irq_req = 1'b1;
    wr(4'b1_011); step(2);          // R7: change while pending, R4 level low
    wr(4'b1_011); step(2);          // R8: same word, no blank
    irq_req = 1'b0; step(2);        // R4: released
    cfg_wr_data = 4'b0_001; step(3); // R10: data without strobe ignored
    irq_req = 1'b1;
    wr(4'b0_110); step(2);          // R6: index 6 selects nothing
    for (int k = 0; k < 8; k++) begin
      wr({1'b0, 3'(k)}); step(1);
      irq_req = ~irq_req; step(1);
      wr({1'b1, 3'(k)}); step(1);
      irq_req = ~irq_req; step(1);
    end
    irq_req = 1'b1;
    wr(4'b1_101); step(3);          // level line 5 pulling low
    @(posedge clk); #2;
    rst = 1'b1;                     // R1: asynchronous release
    #1;
    checks++;
    if (pin_oe !== '0) begin
      errors++;
      $display("FAIL R1: oe=%b expected %b", pin_oe, 6'b0);
    end
    step(2);
    rst = 1'b0;
    step(3);
    wr(4'b0_100); step(1);
    irq_req = 1'b0; step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule